// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block steps a multi-register memory transfer one word at a time. A single `start_i` pulse brings in three values: a base address, a register mask with one bit for each register, and a two-bit addressing mode. From then on the sequencer presents one beat at a time on a valid/ready handshake toward the memory side. Each beat carries a word address and the index of the register that goes with it. Registers are visited in ascending index order, so the lowest-numbered register always pairs with the lowest address, whichever mode is in use.

The four modes choose between upward and downward block placement, and whether the block includes the base word or starts one word beyond it. The block placement is computed once, at start, from the number of set bits in the mask. After that, every accepted beat moves the address up by one word. When the final beat is accepted, the block drops `busy_o` and pulses `done_o` for one cycle. If writeback was requested at start, it also offers the updated base value. An empty mask completes at once, with no beats. Memory access and register-file writes belong to the surrounding datapath.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `beat_valid_o` and `wb_valid_o` are all low.
- R2: Mode encoding is 0 = up from base, 1 = up from base+4, 2 = down ending at base, 3 = down ending at base-4. In mode 0 the first beat address equals the base, and each following beat is 4 higher than the one before it.
- R3: In mode 1, with n set mask bits, the beat addresses are base+4, base+8, and so on up to base+4n.
- R4: In mode 2, the lowest beat address is base-4n+4, so the last beat lands on the base.
- R5: In mode 3, the lowest beat address is base-4n, so the last beat lands on base-4.
- R6: Beat indices are the set bit positions of the mask in ascending order. `beat_last_o` is high only on the beat with the highest set index.
- R7: A beat advances only on a rising edge where `beat_valid_o` and `beat_ready_i` are both high. While ready is low, the address, index and last flag hold.
- R8: `done_o` goes high for exactly one cycle, on the cycle after the final beat is accepted. `busy_o` is low in that cycle.
- R9: A start with an all-zero mask raises `done_o` on the next cycle and issues no beat.
- R10: `wb_valid_o` is high together with `done_o` exactly when `wb_en_i` was high at start. `wb_base_o` is then base+4n for modes 0 and 1, and base-4n for modes 2 and 3 (base itself for an empty mask).
- R11: `start_i` and the start operands are ignored while `busy_o` is high. The transfer in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| base_i | input | ADDR_W | Base register value |
| list_i | input | NREG | Register mask, bit i selects register i |
| mode_i | input | 2 | Addressing mode (see R2) |
| wb_en_i | input | 1 | Request the updated base at completion |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| beat_valid_o | output | 1 | Beat address and index are valid |
| beat_ready_i | input | 1 | Memory side accepts the beat |
| beat_addr_o | output | ADDR_W | Word address of the current beat |
| beat_idx_o | output | $clog2(NREG) | Register index of the current beat |
| beat_last_o | output | 1 | Current beat is the final one |
| wb_valid_o | output | 1 | Updated base is offered (with done) |
| wb_base_o | output | ADDR_W | Updated base value |

## Verification
The hardest cases to reach from the ports are those that touch the mask and the handshake at the same moment. One is a stall on the final beat. Another is a second start request that arrives while a one-beat transfer is finishing: the request must not be taken, yet `start_i` must be low again by the time the block goes idle. The bench reaches these cases by sweeping every mode over several mask families: empty, each single bit, full, both ends only, and pseudo-random masks. A pseudo-random ready pattern stalls roughly a quarter of the beats. On chosen runs the bench holds `start_i` high with different operands during the first beat. After each start it also corrupts the start operands, which shows that the transfer was latched when it was accepted.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        XM_UP_AT   = 2'd0,
        XM_UP_NEXT = 2'd1,
        XM_DN_AT   = 2'd2,
        XM_DN_PREV = 2'd3
    } xfer_mode_e;

endpackage

// File: rtl/blk_xfer_popcnt.sv
module blk_xfer_popcnt #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/blk_xfer_lowpick.sv
module blk_xfer_lowpick #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/blk_xfer_addrgen.sv
module blk_xfer_addrgen
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CW     = 5
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CW-1:0]     cnt_i,
    input  xfer_mode_e        mode_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_o
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] span;

    assign span = {{(ADDR_W-CW){1'b0}}, cnt_i} << 2;

    always_comb begin
        unique case (mode_i)
            XM_UP_AT:   first_o = base_i;
            XM_UP_NEXT: first_o = base_i + WORD_BYTES;
            XM_DN_AT:   first_o = base_i - span + WORD_BYTES;
            default:    first_o = base_i - span;
        endcase
        wb_o = (mode_i == XM_UP_AT || mode_i == XM_UP_NEXT) ? base_i + span
                                                             : base_i - span;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [NREG-1:0]           list_i,
    input  logic [1:0]                mode_i,
    input  logic                      wb_en_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      beat_valid_o,
    input  logic                      beat_ready_i,
    output logic [ADDR_W-1:0]         beat_addr_o,
    output logic [$clog2(NREG)-1:0]   beat_idx_o,
    output logic                      beat_last_o,
    output logic                      wb_valid_o,
    output logic [ADDR_W-1:0]         wb_base_o
);
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              wbv;
        logic              wben;
        logic [NREG-1:0]   left;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb;
    } seq_st_t;

    seq_st_t state_d, state_q;

    logic [CNT_W-1:0]  start_cnt;
    logic [ADDR_W-1:0] start_first;
    logic [ADDR_W-1:0] start_wb;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_last;
    logic              fire;

    blk_xfer_popcnt #(.W(NREG), .CW(CNT_W)) u_cnt (
        .vec_i (list_i),
        .cnt_o (start_cnt)
    );

    blk_xfer_addrgen #(.ADDR_W(ADDR_W), .CW(CNT_W)) u_agen (
        .base_i  (base_i),
        .cnt_i   (start_cnt),
        .mode_i  (xfer_mode_e'(mode_i)),
        .first_o (start_first),
        .wb_o    (start_wb)
    );

    blk_xfer_lowpick #(.W(NREG), .IW(IDX_W)) u_pick (
        .vec_i (state_q.left),
        .idx_o (cur_idx)
    );

    // Only one bit left in the mask: this beat is the final one.
    assign cur_last = ((state_q.left & (state_q.left - 1'b1)) == '0);
    assign fire     = state_q.busy && beat_ready_i;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.wbv  = 1'b0;
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.wb   = start_wb;
                state_d.wben = wb_en_i;
                if (start_cnt == '0) begin
                    state_d.done = 1'b1;
                    state_d.wbv  = wb_en_i;
                end else begin
                    state_d.busy = 1'b1;
                    state_d.left = list_i;
                    state_d.addr = start_first;
                end
            end
        end else if (fire) begin
            state_d.left = state_q.left & ~(NREG'(1) << cur_idx);
            state_d.addr = state_q.addr + WORD_BYTES;
            if (cur_last) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                state_d.wbv  = state_q.wben;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o       = state_q.busy;
    assign done_o       = state_q.done;
    assign beat_valid_o = state_q.busy;
    assign beat_addr_o  = state_q.addr;
    assign beat_idx_o   = cur_idx;
    assign beat_last_o  = state_q.busy && cur_last;
    assign wb_valid_o   = state_q.wbv;
    assign wb_base_o    = state_q.wb;
endmodule

module blk_xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic                    beat_valid_o,
    input logic                    beat_ready_i,
    input logic [ADDR_W-1:0]       beat_addr_o,
    input logic [$clog2(NREG)-1:0] beat_idx_o,
    input logic                    beat_last_o,
    input logic                    wb_valid_o
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
            && $stable(beat_idx_o) && $stable(beat_last_o));

    // R2
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i && !beat_last_o |=>
            beat_valid_o && beat_addr_o == $past(beat_addr_o) + ADDR_W'(4));

    // R6
    idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i && !beat_last_o |=> beat_idx_o > $past(beat_idx_o));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i && beat_last_o |=> done_o && !busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !beat_valid_o);

    // R10
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !(beat_valid_o && beat_ready_i && beat_last_o) |=> busy_o);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (.*);

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        beat_ready_i = 1'b0;
    logic        busy_o, done_o, beat_valid_o, beat_last_o, wb_valid_o;
    logic [31:0] beat_addr_o, wb_base_o;
    logic [3:0]  beat_idx_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] rdy_lfsr = 16'hACE1;

    blk_xfer_seq u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] step16(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic run(input logic [31:0] base, input logic [15:0] lst,
                       input logic [1:0] md, input logic wb, input logic poke);
        int n;
        int k;
        logic [31:0] low, wbx;
        logic rdy;
        string mreq;
        n = $countones(lst);
        case (md)
            2'd0: begin low = base;                  mreq = "R2"; end
            2'd1: begin low = base + 32'd4;          mreq = "R3"; end
            2'd2: begin low = base - 32'(4*n) + 32'd4; mreq = "R4"; end
            default: begin low = base - 32'(4*n);    mreq = "R5"; end
        endcase
        wbx = (md < 2'd2) ? base + 32'(4*n) : base - 32'(4*n);
        @(negedge clk);
        start_i = 1'b1; base_i = base; list_i = lst; mode_i = md; wb_en_i = wb;
        @(negedge clk);
        start_i = 1'b0; base_i = ~base; list_i = ~lst; mode_i = ~md; wb_en_i = ~wb;
        if (n != 0) begin
            k = 0;
            for (int j = 0; j < 16; j++) begin
                if (lst[j]) begin
                    rdy = 1'b1;
                    do begin
                        string areq;
                        areq = rdy ? mreq : "R7";
                        rdy = rdy_lfsr[0] | rdy_lfsr[2];
                        beat_ready_i = rdy;
                        if (poke && k == 0) begin
                            start_i = 1'b1; base_i = 32'h5555_0000; list_i = 16'h0001;
                        end
                        chk(beat_valid_o === 1'b1, "R7", 32'(beat_valid_o), 32'd1);
                        chk(beat_addr_o === low + 32'(4*k), areq, beat_addr_o, low + 32'(4*k));
                        chk(beat_idx_o === 4'(j), "R6", 32'(beat_idx_o), 32'(j));
                        chk(beat_last_o === (k == n - 1), "R6", 32'(beat_last_o),
                            32'(k == n - 1));
                        @(negedge clk);
                        start_i = 1'b0;
                        rdy_lfsr = step16(rdy_lfsr);
                    end while (!rdy);
                    k++;
                end
            end
            beat_ready_i = 1'b0;
            chk(done_o === 1'b1 && busy_o === 1'b0, poke ? "R11" : "R8",
                {30'd0, done_o, busy_o}, 32'h2);
        end else begin
            chk(done_o === 1'b1 && beat_valid_o === 1'b0 && busy_o === 1'b0, "R9",
                {29'd0, done_o, beat_valid_o, busy_o}, 32'h4);
        end
        chk(wb_valid_o === wb, "R10", 32'(wb_valid_o), 32'(wb));
        if (wb) chk(wb_base_o === wbx, "R10", wb_base_o, wbx);
        @(negedge clk);
        chk(done_o === 1'b0 && wb_valid_o === 1'b0 && beat_valid_o === 1'b0, "R8",
            {29'd0, done_o, wb_valid_o, beat_valid_o}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lg;
        logic [31:0] bs;
        lg = 16'h1D2B;
        bs = 32'h2000_0040;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy_o, done_o, beat_valid_o, wb_valid_o} === 4'b0, "R1",
            {28'd0, busy_o, done_o, beat_valid_o, wb_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, beat_valid_o, wb_valid_o} === 4'b0, "R1",
            {28'd0, busy_o, done_o, beat_valid_o, wb_valid_o}, 32'h0);
        for (int m = 0; m < 4; m++) begin
            run(bs, 16'h0000, 2'(m), 1'b1, 1'b0);
            run(32'h0000_0000, 16'h0000, 2'(m), 1'b0, 1'b0);
            run(32'h0000_0000, 16'hFFFF, 2'(m), 1'b1, 1'b0);
            run(bs, 16'h8001, 2'(m), 1'b1, 1'b1);
            for (int b = 0; b < 16; b++) begin
                run(bs + 32'(b * 64), 16'(1) << b, 2'(m), b[0], b[1] & b[2]);
            end
            for (int r = 0; r < 40; r++) begin
                lg = step16(lg);
                bs = {step16(bs[31:16]), bs[15:2] ^ lg[13:0], 2'b00};
                run(bs, lg, 2'(m), lg[3], lg[5] & lg[9]);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule